// File: doc/BRIEF.md
# SPI Serial Clock Generator with Linear and Power-of-Two Division

This block derives the serial clock of an SPI master from a fast module clock. One rate-select input picks the division law. With it set, a linear 8-bit count gives a clock of the module clock divided by 2*(N+1). With it clear, a 4-bit exponent gives a clock of the module clock divided by 2^(M+1). The linear law reaches down to one five-hundred-twelfth of the module clock. The exponent law covers the slowest rates, down to one sixty-five-thousand-five-hundred-thirty-sixth.

The transfer engine raises `enable` to run the clock and lowers it to stop. While `enable` is low, the divider count and edge phase are cleared. The block also captures the divider fields and the polarity and phase bits in this state, so changing a field during a transfer cannot shorten or stretch a clock period. On every serial clock edge, exactly one of two single-cycle strobes fires, and it appears in the same cycle as the new clock level. `shiftStb` tells the shift register to drive the next bit. `sampleStb` tells it to capture the incoming bit. The clock phase bit decides which edge gets which strobe, so all four SPI modes are covered.

When phase is 0, the first data bit must already be driven before the first edge; the shift register does this when it loads.

Top module: `spi_sclk_gen`

## Requirements
- R1: With `rateSel`=1, the serial clock period is 2*(`linDiv`+1) module clock cycles, so `linDiv`=255 gives one cycle of `sclk` per 512 module clocks.
- R2: With `rateSel`=0, the serial clock period is 2^(`powDiv`+1) module clock cycles.
- R3: The fastest setting (`rateSel`=1, `linDiv`=0) toggles `sclk` on every module clock edge. The slowest setting (`rateSel`=0, `powDiv`=15) holds each `sclk` level for 32768 module clocks.
- R4: While `enable` is low, `sclk` equals the `cpol` value sampled on the previous clock edge, and both strobes are 0. Polarity 0 idles low and polarity 1 idles high.
- R5: Count H as the half period in module clocks. After `enable` is first sampled high, the first `sclk` edge appears H cycles later, and `sclk` then changes every H cycles; no two edges are ever closer than H cycles.
- R6: With `cpha`=0 (modes 0 and 2), `sampleStb` pulses with each leading edge (odd edges 1, 3, ...) and `shiftStb` pulses with each trailing edge (even edges).
- R7: With `cpha`=1 (modes 1 and 3), `shiftStb` pulses with each leading edge and `sampleStb` pulses with each trailing edge.
- R8: `shiftStb` and `sampleStb` are never high together. Each is a single-cycle pulse that appears only in the cycle in which `sclk` has just changed.
- R9: Changes to `rateSel`, `linDiv` or `powDiv` while `enable` is high have no effect on `sclk` or on the strobes until `enable` has been low for a cycle.
- R10: Lowering `enable` for one cycle clears the divider. A following transfer places its first edge a full H cycles after `enable` is sampled high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Transfer active; low clears the divider and captures the settings |
| rateSel | input | 1 | 1 selects the linear law, 0 the power-of-two law |
| linDiv | input | LIN_W | Linear divider count N |
| powDiv | input | POW_W | Power-of-two exponent M |
| cpol | input | 1 | Clock polarity (idle level) |
| cpha | input | 1 | Clock phase (0 samples on the leading edge) |
| sclk | output | 1 | Serial clock |
| shiftStb | output | 1 | One-cycle pulse: drive the next data bit |
| sampleStb | output | 1 | One-cycle pulse: capture the incoming data bit |

## Verification
The checker compares the strobe position against the live `cpol` and `cpha` pins. It therefore takes for granted that the mode bits stay constant while `enable` is high. The divider fields may change at any time, because the checker keeps its own copy of the half period, captured while the block is idle. The stimulus keeps to this assumption: polarity and phase change only during idle cycles, and the mid-transfer test disturbs only the divider fields and the rate select.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

  // Control-to-datapath strobes.
  typedef struct packed {
    logic load;  // capture the divider settings
    logic run;   // advance the half-period counter
  } divCtlT;

  // Width needed to hold the largest half period of either law.
  function automatic int halfWidth(input int linW, input int powW);
    int linNeed;
    int powNeed;
    linNeed = linW + 1;
    powNeed = 2 ** powW;
    return (linNeed > powNeed) ? linNeed : powNeed;
  endfunction

endpackage

// File: rtl/sclk_div_path.sv
module sclk_div_path
  import spi_sclk_pkg::*;
#(
  parameter int LIN_W  = 8,
  parameter int POW_W  = 4,
  parameter int HALF_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCtlT           ctl,
  input  logic             rateSel,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [POW_W-1:0] powDiv,
  output logic             tick
);

  logic [HALF_W-1:0] halfLenQ;
  logic [HALF_W-1:0] halfLenD;
  logic [HALF_W-1:0] countQ;

  // Half period in module clocks for the selected law.
  always_comb begin
    if (rateSel) halfLenD = HALF_W'(linDiv) + HALF_W'(1);
    else         halfLenD = HALF_W'(1) << powDiv;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         halfLenQ <= HALF_W'(1);
    else if (ctl.load) halfLenQ <= halfLenD;
  end

  assign tick = ctl.run && (countQ == (halfLenQ - HALF_W'(1)));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         countQ <= '0;
    else if (!ctl.run) countQ <= '0;
    else if (tick)     countQ <= '0;
    else               countQ <= countQ + HALF_W'(1);
  end

endmodule

// File: rtl/sclk_edge_ctl.sv
module sclk_edge_ctl
  import spi_sclk_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   enable,
  input  logic   cpol,
  input  logic   cpha,
  input  logic   tick,
  output divCtlT ctl,
  output logic   sclk,
  output logic   shiftStb,
  output logic   sampleStb
);

  logic cpolQ;
  logic cphaQ;
  logic phaseQ;   // 0 before a leading edge, 1 before a trailing edge

  always_comb begin
    ctl.load = !enable;
    ctl.run  = enable;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cpolQ <= 1'b0;
      cphaQ <= 1'b0;
    end else if (!enable) begin
      cpolQ <= cpol;
      cphaQ <= cpha;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ    <= 1'b0;
      shiftStb  <= 1'b0;
      sampleStb <= 1'b0;
    end else if (!enable) begin
      phaseQ    <= 1'b0;
      shiftStb  <= 1'b0;
      sampleStb <= 1'b0;
    end else begin
      if (tick) phaseQ <= ~phaseQ;
      // Leading edge (phaseQ=0) samples when cpha=0; trailing when cpha=1.
      sampleStb <= tick && (phaseQ == cphaQ);
      shiftStb  <= tick && (phaseQ != cphaQ);
    end
  end

  assign sclk = cpolQ ^ phaseQ;

endmodule

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen
  import spi_sclk_pkg::*;
#(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enable,
  input  logic             rateSel,
  input  logic [LIN_W-1:0] linDiv,
  input  logic [POW_W-1:0] powDiv,
  input  logic             cpol,
  input  logic             cpha,
  output logic             sclk,
  output logic             shiftStb,
  output logic             sampleStb
);

  localparam int HALF_W = halfWidth(LIN_W, POW_W);

  divCtlT divCtl;
  logic   tick;

  sclk_edge_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .enable    (enable),
    .cpol      (cpol),
    .cpha      (cpha),
    .tick      (tick),
    .ctl       (divCtl),
    .sclk      (sclk),
    .shiftStb  (shiftStb),
    .sampleStb (sampleStb)
  );

  sclk_div_path #(
    .LIN_W  (LIN_W),
    .POW_W  (POW_W),
    .HALF_W (HALF_W)
  ) u_path (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (divCtl),
    .rateSel (rateSel),
    .linDiv  (linDiv),
    .powDiv  (powDiv),
    .tick    (tick)
  );

endmodule

// File: rtl/spi_sclk_chk.sv
module spi_sclk_chk #(
  parameter int LIN_W = 8,
  parameter int POW_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             enable,
  input logic             rateSel,
  input logic [LIN_W-1:0] linDiv,
  input logic [POW_W-1:0] powDiv,
  input logic             cpol,
  input logic             cpha,
  input logic             sclk,
  input logic             shiftStb,
  input logic             sampleStb
);

  localparam int HW = spi_sclk_pkg::halfWidth(LIN_W, POW_W);

  logic [HW-1:0] expHalf;
  logic [HW-1:0] gapCnt;
  logic          havePrev;
  logic          anyStb;

  assign anyStb = shiftStb || sampleStb;

  // Independent tracker of the spacing between successive edges.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      expHalf  <= HW'(1);
      gapCnt   <= '0;
      havePrev <= 1'b0;
    end else if (!enable) begin
      expHalf  <= rateSel ? (HW'(linDiv) + HW'(1)) : (HW'(1) << powDiv);
      gapCnt   <= '0;
      havePrev <= 1'b0;
    end else if (anyStb) begin
      gapCnt   <= '0;
      havePrev <= 1'b1;
    end else begin
      gapCnt   <= gapCnt + HW'(1);
    end
  end

  assert_idle_level_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && !$past(enable)) |-> (sclk == $past(cpol)));

  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !anyStb);

  assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (!rstN)
    !(shiftStb && sampleStb));

  assert_strobe_on_edge_R8: assert property (@(posedge clk) disable iff (!rstN)
    anyStb |-> (sclk != $past(sclk)));

  assert_edge_spacing_R5: assert property (@(posedge clk) disable iff (!rstN)
    (enable && anyStb && havePrev) |-> (gapCnt == expHalf - HW'(1)));

  assert_sample_leading_R6: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && !cpha) |-> (sclk != cpol));

  assert_sample_trailing_R7: assert property (@(posedge clk) disable iff (!rstN)
    (sampleStb && cpha) |-> (sclk == cpol));

endmodule

bind spi_sclk_gen spi_sclk_chk #(
  .LIN_W (LIN_W),
  .POW_W (POW_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .enable    (enable),
  .rateSel   (rateSel),
  .linDiv    (linDiv),
  .powDiv    (powDiv),
  .cpol      (cpol),
  .cpha      (cpha),
  .sclk      (sclk),
  .shiftStb  (shiftStb),
  .sampleStb (sampleStb)
);

// File: tb/test_spi_sclk_gen.sv
`timescale 1ns/100ps
module test_spi_sclk_gen;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       rateSel = 1'b1;
  logic [7:0] linDiv = 8'd0;
  logic [3:0] powDiv = 4'd0;
  logic       cpol = 1'b0;
  logic       cpha = 1'b0;
  logic       sclk;
  logic       shiftStb;
  logic       sampleStb;

  int  errors = 0;
  int  checks = 0;
  int  bothHigh = 0;
  bit  done = 1'b0;

  always #2.5 clk = ~clk;

  spi_sclk_gen i_spi_sclk_gen (
    .clk(clk), .rstN(rstN), .enable(enable), .rateSel(rateSel),
    .linDiv(linDiv), .powDiv(powDiv), .cpol(cpol), .cpha(cpha),
    .sclk(sclk), .shiftStb(shiftStb), .sampleStb(sampleStb)
  );

  // {rateSel, linDiv[7:0], powDiv[3:0], cpol, cpha, edges[4:0]}
  localparam int NVEC = 8;
  localparam logic [19:0] VEC [NVEC] = '{
    {1'b1, 8'd0,   4'd0, 1'b0, 1'b0, 5'd8},
    {1'b1, 8'd3,   4'd0, 1'b1, 1'b1, 5'd6},
    {1'b1, 8'd9,   4'd0, 1'b0, 1'b1, 5'd4},
    {1'b0, 8'd0,   4'd0, 1'b1, 1'b0, 5'd6},
    {1'b0, 8'd0,   4'd3, 1'b0, 1'b0, 5'd4},
    {1'b0, 8'd0,   4'd5, 1'b1, 1'b1, 5'd4},
    {1'b1, 8'd255, 4'd0, 1'b1, 1'b0, 5'd2},
    {1'b1, 8'd6,   4'd0, 1'b0, 1'b1, 5'd4}
  };

  always @(negedge clk) if (shiftStb && sampleStb) bothHigh++;

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Runs one transfer and compares every cycle against the model.
  task automatic runXfer(input logic rs, input logic [7:0] ln, input logic [3:0] pw,
                         input logic pl, input logic ph, input int edges,
                         input string rateTag, input string strbTag, input bit midChange);
    int h;
    int sBad, tBad, sAct, sExp, tAct, tExp;
    rateSel = rs; linDiv = ln; powDiv = pw; cpol = pl; cpha = ph; enable = 1'b0;
    step(); step();
    h = rs ? (int'(ln) + 1) : (1 << pw);
    sBad = 0; tBad = 0; sAct = 0; sExp = 0; tAct = 0; tExp = 0;
    enable = 1'b1;
    for (int n = 1; n <= h * edges; n++) begin
      int k;
      bit strb, lead, eSclk, eSamp, eShift;
      step();
      if (midChange && n == 2) begin
        rateSel = ~rs; linDiv = 8'd0; powDiv = 4'd0;
      end
      k = n / h;
      strb = (n % h) == 0;
      lead = (k % 2) == 1;
      eSclk = pl ^ lead;
      eSamp = strb && (lead == !ph);
      eShift = strb && !eSamp;
      if (sclk !== eSclk && sBad == 0) begin sAct = sclk; sExp = eSclk; end
      if (sclk !== eSclk) sBad++;
      if ((sampleStb !== eSamp || shiftStb !== eShift) && tBad == 0) begin
        tAct = {sampleStb, shiftStb}; tExp = {eSamp, eShift};
      end
      if (sampleStb !== eSamp || shiftStb !== eShift) tBad++;
    end
    check(sBad == 0, rateTag, "sclk sequence", sAct, sExp);
    check(tBad == 0, strbTag, "strobe {sample,shift}", tAct, tExp);
    enable = 1'b0;
    rateSel = rs; linDiv = ln; powDiv = pw;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // Reset state
    check(sclk == 1'b0 && !shiftStb && !sampleStb, "R4", "reset outputs",
          {sclk, shiftStb, sampleStb}, 0);
    rstN = 1'b1;
    step();

    // Vector table: R1/R2 rate laws, R5 edge placement, R6/R7 strobe mapping
    for (int v = 0; v < NVEC; v++) begin
      logic [19:0] e;
      e = VEC[v];
      runXfer(e[19], e[18:11], e[10:7], e[6], e[5], int'(e[4:0]),
              e[19] ? "R1/R5" : "R2/R5", e[5] ? "R7" : "R6", 1'b0);
    end

    // R4: idle level follows polarity, strobes quiet
    cpol = 1'b1; enable = 1'b0;
    step();
    check(sclk == 1'b1 && !shiftStb && !sampleStb, "R4", "idle high",
          {sclk, shiftStb, sampleStb}, 4);
    cpol = 1'b0;
    step();
    check(sclk == 1'b0 && !shiftStb && !sampleStb, "R4", "idle low",
          {sclk, shiftStb, sampleStb}, 0);

    // R3: fastest rate toggles every cycle
    runXfer(1'b1, 8'd0, 4'd0, 1'b1, 1'b0, 6, "R3", "R3", 1'b0);

    // R9: field changes during a transfer are ignored
    runXfer(1'b1, 8'd3, 4'd0, 1'b0, 1'b0, 6, "R9", "R9", 1'b1);

    // R10: interrupted transfer, then a fresh one with full first half period
    rateSel = 1'b1; linDiv = 8'd4; cpol = 1'b0; cpha = 1'b0; enable = 1'b0;
    step();
    enable = 1'b1;
    repeat (7) step();
    enable = 1'b0;
    step();
    check(sclk == 1'b0 && !shiftStb && !sampleStb, "R10", "return to idle",
          {sclk, shiftStb, sampleStb}, 0);
    runXfer(1'b1, 8'd4, 4'd0, 1'b0, 1'b0, 4, "R10", "R10", 1'b0);

    // R3: slowest rate, 32768 cycles per level
    runXfer(1'b0, 8'd0, 4'd15, 1'b0, 1'b1, 2, "R3", "R3", 1'b0);

    // R8: strobes never coincide
    check(bothHigh == 0, "R8", "cycles with both strobes", bothHigh, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule